// File: doc/BRIEF.md
# Interrupt Enable, Status and Clear Aggregator

This block collects interrupt requests from a multi-channel accelerator controller and presents them to a processor as one active-high interrupt line. Request inputs come in two groups: per-channel events (done or error) and per-execution-unit events. Both groups are packed into one source vector. The channel sources occupy the low bits and the execution-unit sources sit directly above them. Software reaches three registers over a simple word-addressed register bus.

The enable register chooses which sources may record an event. Each request input is sampled once per clock as a level. While a source is enabled, its sampled level sets the matching bit of the status register. That bit stays set until software clears it. The interrupt line is a registered OR of all status bits.

Clearing goes through a dedicated clear register rather than through the status register. Writing a one to a bit of the clear register removes the matching status bit. Writing a zero to a bit of the clear register has no effect. Each clear bit drops back to zero by itself one cycle after the write. If a source is still active when its clear takes effect, the set has priority, so the bit stays set and the line stays asserted.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the enable register, the status register and `irq` are all zero.
- R2: A status bit becomes set only when its source was sampled high while the matching enable bit was one. A source input that is high at clock edge k sets its status bit at edge k+1.
- R3: `irq` is high exactly when at least one status bit was set one cycle earlier.
- R4: A status bit is cleared only by reset or by writing a one to the matching bit of the clear register. The write at edge k clears the bit at edge k+1.
- R5: Writing zero bits to the clear register does not change status. Writing to the status offset does not change status.
- R6: Bits of the clear register return to zero one cycle after they are written, and the clear register reads back as zero.
- R7: When a clear removes the last set status bit, `irq` drops one cycle after the status register empties.
- R8: If a source is still active and enabled when its clear takes effect, its status bit remains set and `irq` stays high.
- R9: If a set and a clear reach the same status bit in the same cycle, the bit ends up set.
- R10: Word offset 0 holds the enable register, offset 1 holds the status register and offset 2 holds the clear register. Offset 3 reads as zero. Read data is registered: it shows the register selected by `bus_addr` at the previous edge. Data bits at and above position N_CHAN+N_UNIT read as zero.
- R11: Channel source i maps to status bit i. Execution-unit source j maps to status bit N_CHAN+j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word offset of the register to read or write |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| chan_evt | input | N_CHAN | Per-channel interrupt request levels |
| unit_evt | input | N_UNIT | Per-execution-unit interrupt request levels |
| irq | output | 1 | Active-high interrupt to the processor |

## Verification
The hardest case to produce from the ports is a set and a clear that reach the same status bit in the same cycle. The request sample register and the clear strobe register each add one cycle of delay, so the collision only occurs when both are launched on the same edge. The stimulus reaches it by raising a channel request in the same cycle as a clear write to that bit, then dropping the request, and finally reading the status back to confirm the bit survived. A related case is a persistent execution-unit request that is cleared while still active. The bench checks that this request keeps the line high. A behavioural model is compared against the read data and `irq` on every clock.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    SEL_ENABLE = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_CLEAR  = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int NSRC = 12,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [NSRC-1:0]   status,
  output logic [NSRC-1:0]   enable,
  output logic [NSRC-1:0]   clr_strobe,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0] rd_d;
  reg_sel_e      sel;

  assign sel = reg_sel_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      enable     <= '0;
      clr_strobe <= '0;
      rdata      <= '0;
    end else begin
      if (wr && sel == SEL_ENABLE) enable <= wdata[NSRC-1:0];
      clr_strobe <= (wr && sel == SEL_CLEAR) ? wdata[NSRC-1:0] : '0;
      rdata      <= rd_d;
    end
  end

  always_comb begin
    rd_d = '0;
    unique case (sel)
      SEL_ENABLE: rd_d[NSRC-1:0] = enable;
      SEL_STATUS: rd_d[NSRC-1:0] = status;
      default:    rd_d = '0;
    endcase
  end

  assert_enable_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (enable == '0));
  assert_strobe_selfclear_R6: assert property (@(posedge clk) disable iff (rst)
    !(wr && sel == SEL_CLEAR) |=> (clr_strobe == '0));
endmodule

// File: rtl/irq_agg_status.sv
module irq_agg_status #(
  parameter int NSRC = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] enable,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] status
);
  logic [NSRC-1:0] src_q;

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src;
  end

  for (genvar b = 0; b < NSRC; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                      status[b] <= 1'b0;
      else if (src_q[b] && enable[b]) status[b] <= 1'b1;
      else if (clr[b])              status[b] <= 1'b0;
    end
  end

  assert_set_needs_enable_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((status & ~$past(status) & ~$past(src_q & enable)) == '0));
  assert_clear_only_by_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(status) & ~status & ~$past(clr)) == '0));
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(src_q & enable & clr) & ~status) == '0));
endmodule

// File: rtl/irq_agg_line.sv
module irq_agg_line #(
  parameter int NSRC = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] status,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |status;
  end

  assert_line_follows_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == ($past(status) != '0)));
  assert_line_drops_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(status) != '0 && status == '0) |=> !irq);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int N_CHAN = 4,
  parameter int N_UNIT = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [N_CHAN-1:0] chan_evt,
  input  logic [N_UNIT-1:0] unit_evt,
  output logic              irq
);
  localparam int NSRC = N_CHAN + N_UNIT;

  logic [NSRC-1:0] src_vec;
  logic [NSRC-1:0] enable;
  logic [NSRC-1:0] clr_strobe;
  logic [NSRC-1:0] status;

  // R11: channels in the low bits, execution units above them
  assign src_vec = {unit_evt, chan_evt};

  irq_agg_regs #(.NSRC(NSRC), .DW(DW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr         (bus_wr),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .status     (status),
    .enable     (enable),
    .clr_strobe (clr_strobe),
    .rdata      (bus_rdata)
  );

  irq_agg_status #(.NSRC(NSRC)) u_status (
    .clk    (clk),
    .rst    (rst),
    .src    (src_vec),
    .enable (enable),
    .clr    (clr_strobe),
    .status (status)
  );

  irq_agg_line #(.NSRC(NSRC)) u_line (
    .clk    (clk),
    .rst    (rst),
    .status (status),
    .irq    (irq)
  );

  assert_status_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (status == '0 && !irq));
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int N_CHAN = 4;
  localparam int N_UNIT = 8;
  localparam int DW     = 32;
  localparam int NSRC   = N_CHAN + N_UNIT;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [N_CHAN-1:0] chan_evt = '0;
  logic [N_UNIT-1:0] unit_evt = '0;
  logic          irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  irq_aggregator #(.N_CHAN(N_CHAN), .N_UNIT(N_UNIT), .DW(DW)) i_irq_aggregator (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_evt(chan_evt),
    .unit_evt(unit_evt), .irq(irq)
  );

  // Behavioural reference: each variable is what the requirements say is held after an edge
  int unsigned m_seen, m_en, m_clr, m_stat, m_rd;
  bit m_irq;
  always @(posedge clk) begin
    if (rst) begin
      m_seen <= 0; m_en <= 0; m_clr <= 0; m_stat <= 0; m_rd <= 0; m_irq <= 0;
    end else begin
      m_seen <= (int'(unit_evt) << N_CHAN) | int'(chan_evt);
      if (bus_wr && bus_addr == 2'd0) m_en <= bus_wdata & ((1 << NSRC) - 1);
      m_clr  <= (bus_wr && bus_addr == 2'd2) ? (bus_wdata & ((1 << NSRC) - 1)) : 0;
      m_stat <= (m_stat & ~m_clr) | (m_seen & m_en);
      m_irq  <= (m_stat != 0);
      case (bus_addr)
        2'd0:    m_rd <= m_en;
        2'd1:    m_rd <= m_stat;
        default: m_rd <= 0;
      endcase
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model (R3, R10)
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R3 irq vs model", irq, m_irq);
      check("R10 rdata vs model", bus_rdata, m_rd);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, input longint exp, input string tag);
    bus_addr = a;
    @(negedge clk);
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    rd(2'd0, 0, "R1 enable after reset");
    rd(2'd1, 0, "R1 status after reset");
    check("R1 irq after reset", irq, 0);

    chan_evt[0] = 1'b1;
    step(4);
    rd(2'd1, 0, "R2 disabled source ignored");

    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, 32'h0000_0FFF, "R10 enable readback upper bits zero");
    step(2);
    rd(2'd1, 32'h1, "R2 enabled source sets status");
    check("R3 irq high", irq, 1);
    chan_evt[0] = 1'b0;
    step(2);

    wr(2'd2, 32'h0);
    step(2);
    rd(2'd1, 32'h1, "R5 zero clear write no effect");
    wr(2'd1, 32'h0);
    step(2);
    rd(2'd1, 32'h1, "R5 status offset write no effect");
    rd(2'd2, 0, "R6 clear reads zero");
    rd(2'd3, 0, "R10 spare offset reads zero");

    wr(2'd2, 32'h1);
    step(1);
    rd(2'd1, 0, "R4 clear removes status");
    check("R7 irq dropped", irq, 0);

    unit_evt[0] = 1'b1;
    step(3);
    rd(2'd1, 32'h1 << N_CHAN, "R11 unit source bit position");
    wr(2'd2, 32'h1 << N_CHAN);
    step(3);
    rd(2'd1, 32'h1 << N_CHAN, "R8 active source survives clear");
    check("R8 irq stays high", irq, 1);
    unit_evt[0] = 1'b0;
    step(1);
    wr(2'd2, 32'h1 << N_CHAN);
    step(2);
    rd(2'd1, 0, "R4 cleared after source idle");

    // R9: request and clear launched on the same edge
    bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h2; chan_evt[1] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; chan_evt[1] = 1'b0;
    step(2);
    rd(2'd1, 32'h2, "R9 set wins over clear");
    wr(2'd2, 32'h2);
    step(2);
    rd(2'd1, 0, "R9 bit clears once request gone");
    check("R7 irq low at end", irq, 0);

    wr(2'd0, 32'h0);
    chan_evt = '1;
    step(4);
    rd(2'd1, 0, "R2 all sources disabled");
    chan_evt = '0;

    rst = 1'b1;
    wr(2'd0, 32'hF);
    rst = 1'b0;
    step(1);
    rd(2'd0, 0, "R1 reset overrides write");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule